// File: doc/BRIEF.md
# Proximity Measurement Cycle Sequencer

This block paces the repeating measurement loop of an optical proximity sensor. While its power-on enable is low it idles in a sleep state. Once the enable is set, it spends one fixed settling step in a start state. It then runs the measurement. First an accumulate phase fires a programmed burst of LED pulses. Then an integration phase runs for a programmed number of steps and ends with a convert strobe, at which the ADC result on the `adc_result` port is captured into a 16-bit data register. An optional wait phase of programmable length follows, and the loop repeats.

Two internal tick generators derive all timing from the system clock. Both periods are parameters given in clock cycles: the LED pulse period and the base step (nominally 2.72 ms). Step counts are programmed in the usual "256 minus register" form. A wait-long flag stretches every wait step by a factor of twelve. Clearing the power-on enable never cuts a conversion short: the machine returns to sleep only at a phase boundary, after the data has been latched.

Top module: `prox_cycle_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `state_q` is 0 (sleep), and `led_drive`, `accum_act`, `integ_act`, `convert_stb`, `data_valid` and `data_q` are all zero.
- R2: In sleep, a high `pwr_on` moves `state_q` to 1 (start) in the next cycle. Start then lasts exactly STEP_CLKS cycles, whatever `wait_en` is.
- R3: State codes are sleep=0, start=1, accumulate=2, integrate=3, wait=4. Each new cycle begins in accumulate if `prox_en` is high, otherwise in wait if `wait_en` is high, otherwise in another start step.
- R4: Accumulate lasts N×PULSE_CLKS cycles, where N is `pulse_cnt`, or 1 when `pulse_cnt` is 0. `led_drive` is high for the first PULSE_CLKS/2 cycles of each period, which gives exactly N pulses. Accumulate is always followed by integrate.
- R5: Integrate lasts (256 − `integ_time`)×STEP_CLKS cycles. It is followed by wait when `wait_en` is high and otherwise by the start of the next cycle.
- R6: Wait lasts (256 − `wait_time`)×STEP_CLKS cycles, or twelve times that when `wait_long` is high.
- R7: `convert_stb` is high only in the last cycle of integrate. The `adc_result` value present in that cycle appears on `data_q` in the next cycle, together with a one-cycle `data_valid` pulse. At no other time does `data_q` change.
- R8: With `pwr_on` low, the machine goes to sleep only at the end of a start, integrate or wait phase. An accumulate already under way completes together with its integrate, and the data is latched. After that integrate the wait phase is skipped.
- R9: `accum_act` is high exactly in the cycles where `state_q` is 2, and `integ_act` exactly in those where it is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Power-on enable for the sequencer |
| prox_en | input | 1 | Include accumulate and integrate in each cycle |
| wait_en | input | 1 | Include the wait phase in each cycle |
| wait_long | input | 1 | Stretch each wait step by twelve |
| pulse_cnt | input | 8 | LED pulses per accumulate (0 counts as 1) |
| integ_time | input | 8 | Integrate length, 256 minus steps |
| wait_time | input | 8 | Wait length, 256 minus steps |
| adc_result | input | 16 | Conversion result from the ADC |
| led_drive | output | 1 | LED drive pulse |
| accum_act | output | 1 | Accumulate phase active |
| integ_act | output | 1 | Integrate phase active |
| convert_stb | output | 1 | Last integrate cycle, result sampled |
| data_q | output | 16 | Latched proximity result |
| data_valid | output | 1 | One-cycle pulse when `data_q` is updated |
| state_q | output | 3 | Current sequencer state |

## Verification
A wrong state code or a wrong transition choice shows on `state_q` in the very cycle it happens. A step or pulse counter that is off by one shows up as a phase that is one tick period too long or too short. The length of every phase is therefore measured in clock cycles and compared against the arithmetic duration, across sweeps of pulse count, integration and wait settings, and the wait-long flag. A latch fault reveals itself in the cycle after integrate, either as a missing `data_valid` or as a `data_q` that differs from the `adc_result` that was driven. The pulse count shows on `led_drive` within one accumulate phase.

// File: rtl/prox_seq_pkg.sv
package prox_seq_pkg;
  typedef enum logic [2:0] {
    PS_SLEEP = 3'd0,
    PS_START = 3'd1,
    PS_ACCUM = 3'd2,
    PS_INTEG = 3'd3,
    PS_WAIT  = 3'd4
  } prox_state_e;
endpackage

// File: rtl/prox_tick_gen.sv
module prox_tick_gen #(
  parameter int PERIOD = 8,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  output logic tick,
  output logic first_half
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (en) cnt <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
  end

  assign tick       = en && (cnt == CW'(PERIOD - 1));
  assign first_half = (cnt < CW'(PERIOD / 2));
endmodule

// File: rtl/prox_phase_load.sv
module prox_phase_load
  import prox_seq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  prox_state_e      phase,
  input  logic [CFG_W-1:0] pulse_cnt,
  input  logic [CFG_W-1:0] integ_time,
  input  logic [CFG_W-1:0] wait_time,
  output logic [CFG_W-1:0] units_m1
);
  always_comb begin
    case (phase)
      PS_ACCUM: units_m1 = (pulse_cnt == '0) ? '0 : pulse_cnt - 1'b1;
      PS_INTEG: units_m1 = ~integ_time;
      PS_WAIT:  units_m1 = ~wait_time;
      default:  units_m1 = '0;
    endcase
  end
endmodule

// File: rtl/prox_cycle_seq.sv
module prox_cycle_seq
  import prox_seq_pkg::*;
#(
  parameter int STEP_CLKS  = 8,
  parameter int PULSE_CLKS = 4,
  parameter int LONG_MULT  = 12,
  parameter int CFG_W      = 8,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on,
  input  logic              prox_en,
  input  logic              wait_en,
  input  logic              wait_long,
  input  logic [CFG_W-1:0]  pulse_cnt,
  input  logic [CFG_W-1:0]  integ_time,
  input  logic [CFG_W-1:0]  wait_time,
  input  logic [DATA_W-1:0] adc_result,
  output logic              led_drive,
  output logic              accum_act,
  output logic              integ_act,
  output logic              convert_stb,
  output logic [DATA_W-1:0] data_q,
  output logic              data_valid,
  output logic [2:0]        state_q
);
  prox_state_e      state, nxt, first_phase;
  logic [CFG_W-1:0] units_left, load_val;
  logic             step_tick, pulse_tick, long_tick, pulse_on;
  logic             step_half_unused, long_half_unused;
  logic             unit_tick, adv;

  prox_tick_gen #(.PERIOD(STEP_CLKS)) u_step (
    .clk(clk), .rst(rst), .restart(adv), .en(1'b1),
    .tick(step_tick), .first_half(step_half_unused));

  prox_tick_gen #(.PERIOD(PULSE_CLKS)) u_pulse (
    .clk(clk), .rst(rst), .restart(adv), .en(1'b1),
    .tick(pulse_tick), .first_half(pulse_on));

  prox_tick_gen #(.PERIOD(LONG_MULT)) u_long (
    .clk(clk), .rst(rst), .restart(adv), .en(step_tick),
    .tick(long_tick), .first_half(long_half_unused));

  prox_phase_load #(.CFG_W(CFG_W)) u_load (
    .phase(nxt), .pulse_cnt(pulse_cnt), .integ_time(integ_time),
    .wait_time(wait_time), .units_m1(load_val));

  // Which timebase advances the unit counter in each phase
  always_comb begin
    case (state)
      PS_START, PS_INTEG: unit_tick = step_tick;
      PS_ACCUM:           unit_tick = pulse_tick;
      PS_WAIT:            unit_tick = wait_long ? long_tick : step_tick;
      default:            unit_tick = 1'b0;
    endcase
  end

  assign adv = (state == PS_SLEEP) ? pwr_on : (unit_tick && units_left == '0);

  assign first_phase = prox_en ? PS_ACCUM : (wait_en ? PS_WAIT : PS_START);

  always_comb begin
    case (state)
      PS_SLEEP: nxt = PS_START;
      PS_START: nxt = pwr_on ? first_phase : PS_SLEEP;
      PS_ACCUM: nxt = PS_INTEG;
      PS_INTEG: nxt = !pwr_on ? PS_SLEEP : (wait_en ? PS_WAIT : first_phase);
      PS_WAIT:  nxt = pwr_on ? first_phase : PS_SLEEP;
      default:  nxt = PS_SLEEP;
    endcase
  end

  assign convert_stb = (state == PS_INTEG) && adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_SLEEP;
      units_left <= '0;
      data_q     <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      if (adv) begin
        state      <= nxt;
        units_left <= load_val;
      end else if (unit_tick) begin
        units_left <= units_left - 1'b1;
      end
      if (convert_stb) begin
        data_q     <= adc_result;
        data_valid <= 1'b1;
      end
    end
  end

  assign led_drive = (state == PS_ACCUM) && pulse_on;
  assign accum_act = (state == PS_ACCUM);
  assign integ_act = (state == PS_INTEG);
  assign state_q   = state;

  AST_WAKE_TO_START: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SLEEP && pwr_on) |=> state == PS_START);                          // R2
  AST_ACCUM_THEN_INTEG: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == PS_ACCUM && state != PS_ACCUM) |-> state == PS_INTEG);          // R4
  AST_NO_SLEEP_FROM_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SLEEP && $past(state) != PS_SLEEP) |-> $past(state) != PS_ACCUM);  // R8
  AST_VALID_AFTER_CONVERT: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> ($past(state) == PS_INTEG && $past(convert_stb)));                // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> $stable(data_q));                                                // R7
endmodule

// File: tb/sim_prox_cycle_seq.sv
module sim_prox_cycle_seq;
  localparam int STEP = 8;
  localparam int PUL  = 4;
  localparam int LM   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_on = 1'b0, prox_en = 1'b0, wait_en = 1'b0, wait_long = 1'b0;
  logic [7:0]  pulse_cnt = '0, integ_time = 8'hFF, wait_time = 8'hFF;
  logic [15:0] adc_result = '0;
  logic        led_drive, accum_act, integ_act, convert_stb, data_valid;
  logic [15:0] data_q;
  logic [2:0]  state_q;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  prox_cycle_seq #(.STEP_CLKS(STEP), .PULSE_CLKS(PUL), .LONG_MULT(LM)) u0 (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .prox_en(prox_en), .wait_en(wait_en),
    .wait_long(wait_long), .pulse_cnt(pulse_cnt), .integ_time(integ_time),
    .wait_time(wait_time), .adc_result(adc_result), .led_drive(led_drive),
    .accum_act(accum_act), .integ_act(integ_act), .convert_stb(convert_stb),
    .data_q(data_q), .data_valid(data_valid), .state_q(state_q));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pwr_on = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(state_q == 3'd0, "R1 state", state_q, 0);
    chk({led_drive, accum_act, integ_act, convert_stb, data_valid} == 5'b0, "R1 outputs",
        {led_drive, accum_act, integ_act, convert_stb, data_valid}, 0);
    chk(data_q == 16'd0, "R1 data", data_q, 0);
  endtask

  // Called at the negedge of the first cycle of a phase; returns at the
  // negedge of the first cycle of the following phase.
  task automatic phase(input logic [2:0] st, input longint len, input int pulses, input string req);
    longint n = 0;
    int hi = 0, rises = 0, acc = 0, ing = 0, conv = 0, conv_last = 0;
    logic prev = 1'b0;
    while (state_q == st && n < 40000) begin
      n++;
      if (led_drive) hi++;
      if (led_drive && !prev) rises++;
      prev = led_drive;
      if (accum_act) acc++;
      if (integ_act) ing++;
      if (convert_stb) begin conv++; conv_last = int'(n); end
      @(negedge clk);
    end
    chk(n == len, req, n, len);
    if (st == 3'd2) begin
      chk(rises == pulses, "R4 pulse count", rises, pulses);
      chk(hi == pulses * (PUL / 2), "R4 led high cycles", hi, pulses * (PUL / 2));
      chk(acc == len, "R9 accum_act", acc, len);
    end else begin
      chk(hi == 0, "R4 led outside accumulate", hi, 0);
    end
    if (st == 3'd3) begin
      chk(ing == len, "R9 integ_act", ing, len);
      chk(conv == 1 && conv_last == len, "R7 convert on last cycle", conv_last, len);
    end else begin
      chk(conv == 0, "R7 no convert outside integrate", conv, 0);
      chk(ing == 0, "R9 integ_act outside integrate", ing, 0);
    end
  endtask

  task automatic run_cfg(input bit pe, input bit we, input bit lg, input int pc,
                         input int pt, input int wt, input logic [15:0] adc);
    int n_p = (pc == 0) ? 1 : pc;
    longint t_int = longint'(256 - pt) * STEP;
    longint t_wait = longint'(256 - wt) * STEP * (lg ? LM : 1);
    do_reset();
    prox_en = pe; wait_en = we; wait_long = lg;
    pulse_cnt = 8'(pc); integ_time = 8'(pt); wait_time = 8'(wt);
    adc_result = adc;
    pwr_on = 1'b1;
    @(negedge clk);
    chk(state_q == 3'd1, "R2 wake to start", state_q, 1);
    phase(3'd1, STEP, 0, "R2 start length");
    if (pe) begin
      chk(state_q == 3'd2, "R3 start to accumulate", state_q, 2);
      phase(3'd2, longint'(n_p) * PUL, n_p, "R4 accumulate length");
      chk(state_q == 3'd3, "R4 accumulate to integrate", state_q, 3);
      phase(3'd3, t_int, 0, "R5 integrate length");
      chk(data_valid == 1'b1, "R7 data_valid", data_valid, 1);
      chk(data_q == adc, "R7 data latched", data_q, adc);
    end else begin
      pwr_on = 1'b0;
    end
    if (we) begin
      chk(state_q == 3'd4, "R3 wait phase entered", state_q, 4);
      phase(3'd4, t_wait, 0, "R6 wait length");
    end
    if (pe) begin
      chk(state_q == 3'd2, "R3 loop to accumulate", state_q, 2);
      adc_result = adc ^ 16'h5A5A;
      pwr_on = 1'b0;
      phase(3'd2, longint'(n_p) * PUL, n_p, "R8 accumulate completes");
      chk(state_q == 3'd3, "R8 integrate after power-down", state_q, 3);
      phase(3'd3, t_int, 0, "R8 integrate completes");
      chk(data_q == (adc ^ 16'h5A5A), "R7 second latch", data_q, adc ^ 16'h5A5A);
    end
    chk(state_q == 3'd0, "R8 back to sleep", state_q, 0);
    repeat (10) @(negedge clk);
    chk(state_q == 3'd0 && !led_drive && !data_valid, "R8 sleep holds", state_q, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    run_cfg(1, 1, 0, 3,   8'hFF, 8'hFE, 16'h1234);
    run_cfg(1, 0, 0, 0,   8'hFF, 8'hFF, 16'hBEEF);  // R4 zero count
    run_cfg(1, 0, 0, 1,   8'hFE, 8'hFF, 16'h0001);
    run_cfg(1, 1, 0, 255, 8'hF0, 8'hFF, 16'hFFFF);
    run_cfg(1, 1, 1, 2,   8'hFF, 8'hFE, 16'h00A5);  // R6 long
    run_cfg(0, 1, 1, 0,   8'hFF, 8'h00, 16'h0000);  // R6 long, 256 steps
    run_cfg(1, 1, 0, 5,   8'h00, 8'h00, 16'h8001);  // R5 R6 256 steps
    run_cfg(0, 1, 0, 0,   8'h00, 8'hF8, 16'h0000);
    for (int p = 1; p <= 8; p++)
      run_cfg(1, 0, 0, p, 8'hFD, 8'hFF, 16'(p * 257));

    // R3: nothing enabled, start repeats until power-down
    do_reset();
    prox_en = 1'b0; wait_en = 1'b0; wait_long = 1'b0;
    pwr_on = 1'b1;
    @(negedge clk);
    begin
      int in_start = 0, leds = 0;
      for (int i = 0; i < 5 * STEP; i++) begin
        if (state_q == 3'd1) in_start++;
        if (led_drive) leds++;
        @(negedge clk);
      end
      chk(in_start == 5 * STEP, "R3 start repeats", in_start, 5 * STEP);
      chk(leds == 0, "R3 no pulses when idle", leds, 0);
    end
    pwr_on = 1'b0;
    phase(3'd1, STEP, 0, "R8 start step completes");
    chk(state_q == 3'd0, "R8 sleep after start", state_q, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule